// File: doc/BRIEF.md
# Interrupt Routing Table Header Validator

The block watches a memory image as it streams past, one byte per clock, and looks for the header of an interrupt routing table in two layouts at once. The long layout may begin only on a 16-byte boundary. It carries a declared total length, and it is accepted only after every byte inside that length has been seen and the bytes sum to zero modulo 256. The short layout has an 8-byte header, may begin at any byte address, and is judged from those eight bytes alone.

Software or a boot engine pulses `scan_start`, holds `region_end` (exclusive end address) steady, and then feeds the region's bytes in ascending, contiguous address order, with `in_valid` marking the cycles that carry a byte. When a table is accepted, the block raises `found` for one cycle. The pulse comes with the table's start address, a flag giving the layout, and the header fields that a later stage needs.

Top module: `irt_scan`

## Requirements
- R1: A long-layout candidate needs bytes 0..3 equal to `PRI_SIG` (byte 0 = bits 7:0), bytes 4..5 equal to `PRI_VER` (little-endian, default bytes 0x00 then 0x01), and a little-endian length in bytes 6..7 that is a multiple of 16 and at least 32.
- R2: A long-layout candidate whose start plus declared length exceeds `region_end` is rejected; a length that ends exactly at `region_end` is allowed.
- R3: A long-layout candidate is accepted only if the 8-bit sum of all bytes from its start through start+length-1 is zero.
- R4: Long-layout candidates are tried only where the start address has bits 3:0 equal to zero; short-layout candidates are tried at every byte address.
- R5: A short-layout header is bytes 0..3 equal to `ALT_SIG`, byte 4 the allocated entry count, byte 5 the used entry count, and bytes 6..7 the little-endian exclusive-IRQ mask. It is rejected when the used count is zero or the allocated count is below the used count.
- R6: An accepted long-layout table always wins. A valid short-layout header is reported only in the cycle after the region's last byte, and only if no long-layout table was reported in that scan. When several short-layout headers are valid, the lowest address is reported.
- R7: On a report, `found_alt` is 0 for the long layout and 1 for the short layout. For the long layout, `found_size` is the length, `found_count` is (length-32)/16, `found_mask` is bytes 10..11 (little-endian), and `found_alloc` is 0. For the short layout, `found_size` is 0, `found_count` is the used count, `found_alloc` is the allocated count, and `found_mask` is bytes 6..7.
- R8: `found` is a single-cycle pulse. For the long layout it comes one clock after the table's final byte. At most one pulse is made per scan, and a new `scan_start` re-arms the block.
- R9: Up to `NSLOT` (default 2) overlapping long-layout candidates are checksummed in parallel. A further candidate that finds every tracker busy is dropped. If two trackers complete on the same byte, the lower start address wins.
- R10: After reset `found` is low. Cycles with `in_valid` low have no effect on detection, whatever `in_addr` and `in_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_start | input | 1 | Clears all scan state; begins a new region |
| region_end | input | ADDR_W | Exclusive end address of the region, held during a scan |
| in_valid | input | 1 | Qualifies `in_addr` and `in_data` |
| in_addr | input | ADDR_W | Address of the byte presented |
| in_data | input | 8 | Image byte |
| found | output | 1 | One-cycle acceptance pulse |
| found_addr | output | ADDR_W | Start address of the accepted table |
| found_alt | output | 1 | 0 = long layout, 1 = short layout |
| found_size | output | 16 | Declared length (long layout) or 0 |
| found_count | output | 12 | Entry count (long) or used count (short) |
| found_alloc | output | 8 | Allocated count (short) or 0 |
| found_mask | output | 16 | Exclusive-IRQ mask |

## Verification
A checksum tracker that drifts, or a window that is shifted by one byte, shows at the ports as a missing or spurious `found` exactly one clock after the table's last byte. It can also show as a wrong start address or mask carried on that same pulse. A lost flag that records a pending short header shows only at the end of the region, as a missing short-layout report. A stuck scan-complete flag suppresses every later report until the next `scan_start`. The bench compares every output in every cycle against a behavioural model of the scan, so any of these faults is caught within one clock of the cycle in which it first changes the ports.

// File: rtl/irt_pkg.sv
// Shared constants and layout offsets for the routing table scanner.
// Assumes byte-wide little-endian header fields.
package irt_pkg;
    localparam int PRI_HDR_BYTES = 32;   // fixed long-layout header
    localparam int ENTRY_BYTES   = 16;   // one routing entry
    localparam int WIN_BYTES     = 8;    // header window (short header length)
    localparam int PRI_MASK_OFS  = 10;   // exclusive mask, long layout
endpackage

// File: rtl/irt_window.sv
// Sliding window of the most recent header bytes.
// Presents WIN bytes: the WIN-1 bytes that came before and the byte on in_data now.
// full is high once WIN-1 bytes have arrived since the last clear.
module irt_window #(
    parameter int WIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic [8*WIN-1:0] view,
    output logic             full
);
    localparam int HIST = WIN - 1;
    localparam int CW   = $clog2(WIN);

    logic [7:0]    hist [HIST];
    logic [CW-1:0] fill;

    // Shift each accepted byte into the history and count fill up to HIST
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fill <= '0;
            for (int k = 0; k < HIST; k++) hist[k] <= 8'h00;
        end else if (in_valid) begin
            for (int k = 0; k < HIST - 1; k++) hist[k] <= hist[k+1];
            hist[HIST-1] <= in_data;
            if (fill != CW'(HIST)) fill <= fill + 1'b1;
        end
    end

    generate
        for (genvar k = 0; k < HIST; k++) begin : g_view
            assign view[8*k +: 8] = hist[k];
        end
    endgenerate
    assign view[8*HIST +: 8] = in_data;
    assign full = (fill == CW'(HIST));
endmodule

// File: rtl/irt_pri_slot.sv
// One checksum tracker for a long-layout candidate.
// It is loaded with the window sum when a header passes. It then adds each later byte
// and flags completion on the byte at start+size-1.
// Assumes it is loaded only while idle and that size >= 32.
module irt_pri_slot #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [7:0]        data,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [15:0]       ld_size,
    input  logic [7:0]        ld_sum,
    output logic              busy,
    output logic              hit_ok,
    output logic [ADDR_W-1:0] base,
    output logic [15:0]       size,
    output logic [15:0]       mask
);
    import irt_pkg::*;

    logic [15:0] idx;
    logic [7:0]  sum_q;
    logic [7:0]  sum_nxt;
    logic        last_now;

    // Completion test for the byte being presented
    always_comb begin
        sum_nxt  = sum_q + data;
        last_now = busy && step && (idx == size - 16'd1);
        hit_ok   = last_now && (sum_nxt == 8'h00);
    end

    // Track offset, running sum and the mask bytes of the open candidate
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            base  <= '0;
            size  <= '0;
            idx   <= '0;
            sum_q <= '0;
            mask  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            base  <= ld_base;
            size  <= ld_size;
            idx   <= 16'(WIN_BYTES);
            sum_q <= ld_sum;
            mask  <= '0;
        end else if (step && busy) begin
            if (last_now) busy <= 1'b0;
            idx   <= idx + 16'd1;
            sum_q <= sum_nxt;
            if (idx == 16'(PRI_MASK_OFS))     mask[7:0]  <= data;
            if (idx == 16'(PRI_MASK_OFS + 1)) mask[15:8] <= data;
        end
    end

    // R9
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx < size));
endmodule

// File: rtl/irt_scan.sv
// Streaming interrupt routing table validator.
// It decodes both header layouts from a sliding window, opens NSLOT checksum trackers
// for aligned long-layout headers, and holds the first valid short header until the
// region ends. It emits one report per scan.
// Assumes the bytes arrive in contiguous ascending address order after scan_start,
// and that region_end is held steady for the whole scan.
module irt_scan #(
    parameter int          ADDR_W  = 16,
    parameter int          NSLOT   = 2,
    parameter logic [31:0] PRI_SIG = 32'h5249_5024,
    parameter logic [15:0] PRI_VER = 16'h0100,
    parameter logic [31:0] ALT_SIG = 32'h5452_4924
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic [ADDR_W-1:0] region_end,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [7:0]        in_data,
    output logic              found,
    output logic [ADDR_W-1:0] found_addr,
    output logic              found_alt,
    output logic [15:0]       found_size,
    output logic [11:0]       found_count,
    output logic [7:0]        found_alloc,
    output logic [15:0]       found_mask
);
    import irt_pkg::*;

    localparam int EW = ADDR_W + 17;
    localparam logic [ADDR_W-1:0] BACK = ADDR_W'(WIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

    logic [8*WIN_BYTES-1:0] view;
    logic                   full;
    logic                   done, alt_pend, live, at_last;
    logic                   cand, alt_now, pri_any, taken;
    logic [ADDR_W-1:0]      base_c, hit_base;
    logic [15:0]            psize, hit_size, hit_mask;
    logic [7:0]             wsum;
    logic [ADDR_W-1:0]      a_addr;
    logic [7:0]             a_alloc, a_used;
    logic [15:0]            a_mask;

    logic [NSLOT-1:0]  s_busy, s_hit, s_start;
    logic [ADDR_W-1:0] s_base [NSLOT];
    logic [15:0]       s_size [NSLOT];
    logic [15:0]       s_mask [NSLOT];

    irt_window #(.WIN(WIN_BYTES)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(scan_start), .in_valid(in_valid),
        .in_data(in_data), .view(view), .full(full)
    );

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            irt_pri_slot #(.ADDR_W(ADDR_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .clr(scan_start), .step(live),
                .data(in_data), .load(s_start[i]), .ld_base(base_c),
                .ld_size(psize), .ld_sum(wsum), .busy(s_busy[i]),
                .hit_ok(s_hit[i]), .base(s_base[i]), .size(s_size[i]),
                .mask(s_mask[i])
            );
        end
    endgenerate

    // Decode both header layouts from the window and sum its bytes
    always_comb begin
        live    = in_valid && !done && !scan_start;
        at_last = live && (in_addr == region_end - ONE);
        base_c  = in_addr - BACK;
        psize   = view[63:48];
        wsum    = 8'h00;
        for (int k = 0; k < WIN_BYTES; k++) wsum = wsum + view[8*k +: 8];
        cand    = live && full && (base_c[3:0] == 4'h0)
               && (view[31:0] == PRI_SIG) && (view[47:32] == PRI_VER)
               && (psize[3:0] == 4'h0) && (psize >= 16'(PRI_HDR_BYTES))
               && ((EW'(base_c) + EW'(psize)) <= EW'(region_end));
        alt_now = live && full && (view[31:0] == ALT_SIG)
               && (view[47:40] != 8'h00) && (view[39:32] >= view[47:40]);
    end

    // Give a new candidate the first idle tracker; pick the earliest completing table
    always_comb begin
        taken    = 1'b0;
        pri_any  = 1'b0;
        hit_base = '0;
        hit_size = '0;
        hit_mask = '0;
        for (int i = 0; i < NSLOT; i++) begin
            s_start[i] = 1'b0;
            if (cand && !s_busy[i] && !taken) begin
                s_start[i] = 1'b1;
                taken      = 1'b1;
            end
            if (s_hit[i] && (!pri_any || s_base[i] < hit_base)) begin
                pri_any  = 1'b1;
                hit_base = s_base[i];
                hit_size = s_size[i];
                hit_mask = s_mask[i];
            end
        end
    end

    // Report the first accepted table and hold the first short header until region end
    always_ff @(posedge clk) begin
        if (!rst_n || scan_start) begin
            done        <= 1'b0;
            alt_pend    <= 1'b0;
            a_addr      <= '0;
            a_alloc     <= '0;
            a_used      <= '0;
            a_mask      <= '0;
            found       <= 1'b0;
            found_addr  <= '0;
            found_alt   <= 1'b0;
            found_size  <= '0;
            found_count <= '0;
            found_alloc <= '0;
            found_mask  <= '0;
        end else begin
            found <= 1'b0;
            if (live) begin
                if (pri_any) begin
                    found       <= 1'b1;
                    found_addr  <= hit_base;
                    found_alt   <= 1'b0;
                    found_size  <= hit_size;
                    found_count <= hit_size[15:4] - 12'd2;
                    found_alloc <= 8'h00;
                    found_mask  <= hit_mask;
                    done        <= 1'b1;
                end else if (at_last && (alt_pend || alt_now)) begin
                    found       <= 1'b1;
                    found_alt   <= 1'b1;
                    found_size  <= 16'h0000;
                    found_addr  <= alt_pend ? a_addr  : base_c;
                    found_count <= {4'h0, (alt_pend ? a_used : view[47:40])};
                    found_alloc <= alt_pend ? a_alloc : view[39:32];
                    found_mask  <= alt_pend ? a_mask  : view[63:48];
                end
                if (at_last) done <= 1'b1;
                if (alt_now && !alt_pend) begin
                    alt_pend <= 1'b1;
                    a_addr   <= base_c;
                    a_alloc  <= view[39:32];
                    a_used   <= view[47:40];
                    a_mask   <= view[63:48];
                end
            end
        end
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> !found);
    // R4
    pri_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !found_alt) |-> (found_addr[3:0] == 4'h0));
    // R1
    pri_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !found_alt) |-> (found_size[3:0] == 4'h0 && found_size >= 16'd32));
    // R5
    alt_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && found_alt) |-> (found_count != 12'd0 && {4'h0, found_alloc} >= found_count));
    // R6
    alt_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && found_alt) |-> $past(in_valid && in_addr == region_end - ONE));
endmodule

// File: tb/irt_scan_tb.sv
`timescale 1ns/1ps
module irt_scan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_start = 1'b0;
    logic [15:0] region_end = 16'h0100;
    logic        in_valid = 1'b0;
    logic [15:0] in_addr = '0;
    logic [7:0]  in_data = '0;
    logic        found, found_alt;
    logic [15:0] found_addr, found_size, found_mask;
    logic [11:0] found_count;
    logic [7:0]  found_alloc;

    irt_scan u_dut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .region_end(region_end),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data), .found(found),
        .found_addr(found_addr), .found_alt(found_alt), .found_size(found_size),
        .found_count(found_count), .found_alloc(found_alloc), .found_mask(found_mask)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0, npulse = 0, last_addr = 0;
    bit last_alt = 0, finished = 0;
    logic [7:0] mem [0:511];

    // expected outputs for the next sample
    bit e_f = 0, e_alt = 0;
    int e_addr = 0, e_size = 0, e_cnt = 0, e_alloc = 0, e_mask = 0;
    // model state
    int q_base[$], q_end[$];
    bit m_done = 0;
    int m_st = 0, m_en = 0;

    function automatic int w16(int a);
        return mem[a] + 256 * mem[a+1];
    endfunction

    function automatic bit pri_hdr_ok(int b);
        int sz = w16(b + 6);
        return mem[b] == 8'h24 && mem[b+1] == 8'h50 && mem[b+2] == 8'h49 && mem[b+3] == 8'h52
            && mem[b+4] == 8'h00 && mem[b+5] == 8'h01 && sz % 16 == 0 && sz >= 32
            && b + sz <= m_en;
    endfunction

    function automatic bit sum_ok(int b, int sz);
        int s = 0;
        for (int i = 0; i < sz; i++) s += mem[b+i];
        return (s % 256) == 0;
    endfunction

    function automatic bit alt_ok(int b);
        return mem[b] == 8'h24 && mem[b+1] == 8'h49 && mem[b+2] == 8'h52 && mem[b+3] == 8'h54
            && mem[b+5] != 0 && mem[b+4] >= mem[b+5];
    endfunction

    // Behavioural model: consumes one byte, sets the expectation for the next cycle
    task automatic model_byte(int a);
        int nb[$], ne[$];
        int hit = -1, hsz = 0, b;
        e_f = 0;
        if (m_done) return;
        foreach (q_base[i]) if (q_end[i] >= a) begin nb.push_back(q_base[i]); ne.push_back(q_end[i]); end
        q_base = nb; q_end = ne;
        foreach (q_base[i])
            if (q_end[i] == a && sum_ok(q_base[i], q_end[i] - q_base[i] + 1) && (hit < 0 || q_base[i] < hit)) begin
                hit = q_base[i]; hsz = q_end[i] - q_base[i] + 1;
            end
        b = a - 7;
        if (b >= m_st && b % 16 == 0 && pri_hdr_ok(b) && q_base.size() < 2) begin
            q_base.push_back(b); q_end.push_back(b + w16(b + 6) - 1);
        end
        if (hit >= 0) begin
            e_f = 1; e_alt = 0; e_addr = hit; e_size = hsz; e_cnt = (hsz - 32) / 16;
            e_alloc = 0; e_mask = w16(hit + 10); m_done = 1;
        end else if (a == m_en - 1) begin
            for (int bb = m_st; bb <= m_en - 8; bb++)
                if (alt_ok(bb)) begin
                    e_f = 1; e_alt = 1; e_addr = bb; e_size = 0; e_cnt = mem[bb+5];
                    e_alloc = mem[bb+4]; e_mask = w16(bb + 6);
                    break;
                end
        end
        if (a == m_en - 1) m_done = 1;
    endtask

    // Compare every output against the model (R7 fields, R8 pulse)
    task automatic cmp();
        checks++;
        if (found !== e_f) begin
            fails++;
            $display("FAIL R8 found actual=%0b expected=%0b at %0t", found, e_f, $time);
        end else if (e_f && (found_addr !== 16'(e_addr) || found_alt !== e_alt ||
                     found_size !== 16'(e_size) || found_count !== 12'(e_cnt) ||
                     found_alloc !== 8'(e_alloc) || found_mask !== 16'(e_mask))) begin
            fails++;
            $display("FAIL R7 actual addr=%h alt=%0b size=%0d cnt=%0d alloc=%0d mask=%h expected addr=%h alt=%0b size=%0d cnt=%0d alloc=%0d mask=%h",
                     found_addr, found_alt, found_size, found_count, found_alloc, found_mask,
                     e_addr, e_alt, e_size, e_cnt, e_alloc, e_mask);
        end
        if (found === 1'b1) begin npulse++; last_addr = found_addr; last_alt = found_alt; end
    endtask

    task automatic step(bit v, int a, logic [7:0] d, bit st);
        @(negedge clk);
        cmp();
        in_valid = v; in_addr = 16'(a); in_data = d; scan_start = st;
        if (st) begin
            e_f = 0; m_done = 0; q_base.delete(); q_end.delete();
        end else if (v) model_byte(a);
        else e_f = 0;
    endtask

    task automatic scan(int st, int en, bit gaps);
        region_end = 16'(en); m_st = st; m_en = en; npulse = 0;
        step(0, 0, 8'h00, 1);
        for (int a = st; a < en; a++) begin
            if (gaps && a % 5 == 3) step(0, en - 1, 8'h24, 0);  // R10 idle cycle with junk
            step(1, a, mem[a], 0);
        end
        repeat (3) step(0, 0, 8'h00, 0);
    endtask

    task automatic scn(string tag, int n, int addr, bit alt);
        checks++;
        if (npulse != n || (n > 0 && (last_addr != addr || last_alt != alt))) begin
            fails++;
            $display("FAIL %s actual pulses=%0d addr=%h alt=%0b expected pulses=%0d addr=%h alt=%0b",
                     tag, npulse, last_addr, last_alt, n, addr, alt);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'h11;
    endtask

    task automatic put_pri(int b, int szf, int ver, int msk);
        mem[b] = 8'h24; mem[b+1] = 8'h50; mem[b+2] = 8'h49; mem[b+3] = 8'h52;
        mem[b+4] = 8'(ver); mem[b+5] = 8'(ver >> 8);
        mem[b+6] = 8'(szf); mem[b+7] = 8'(szf >> 8);
        mem[b+10] = 8'(msk); mem[b+11] = 8'(msk >> 8);
    endtask

    // Set the last byte of a table so that its sum is zero (plus one when bad)
    task automatic seal(int b, int len, bit bad);
        int s = 0;
        for (int i = 0; i < len - 1; i++) s += mem[b+i];
        mem[b+len-1] = 8'((256 - (s % 256)) % 256 + (bad ? 1 : 0));
    endtask

    task automatic put_alt(int b, int alloc, int used, int msk);
        mem[b] = 8'h24; mem[b+1] = 8'h49; mem[b+2] = 8'h52; mem[b+3] = 8'h54;
        mem[b+4] = 8'(alloc); mem[b+5] = 8'(used); mem[b+6] = 8'(msk); mem[b+7] = 8'(msk >> 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R10 reset state
        if (found !== 1'b0) begin fails++; $display("FAIL R10 reset found actual=%0b expected=0", found); end
        rst_n = 1'b1;

        // R3 R7 valid long table with a second valid one later (R8 first only), gapped feed
        clear_mem(); put_pri(16'h40, 64, 16'h0100, 16'h0C20); seal(16'h40, 64, 0);
        put_pri(16'hC0, 32, 16'h0100, 16'h0001); seal(16'hC0, 32, 0);
        scan(0, 256, 1); scn("R3", 1, 16'h40, 0);
        scan(0, 256, 0); scn("R8", 1, 16'h40, 0);   // re-armed by scan_start

        // R3 R5 bad checksum long table, short header at an odd address
        clear_mem(); put_pri(16'h20, 32, 16'h0100, 16'h0003); seal(16'h20, 32, 1);
        put_alt(16'h93, 5, 3, 16'h8001);
        scan(0, 256, 0); scn("R5", 1, 16'h93, 1);

        // R4 long header at unaligned start ignored
        clear_mem(); put_pri(16'h48, 32, 16'h0100, 16'h0010); seal(16'h48, 32, 0);
        scan(0, 256, 0); scn("R4", 0, 0, 0);

        // R2 overrun rejected, exact fit accepted
        clear_mem(); put_pri(16'hE0, 64, 16'h0100, 16'h0100); seal(16'hE0, 64, 0);
        scan(0, 256, 0); scn("R2", 0, 0, 0);
        clear_mem(); put_pri(16'hE0, 32, 16'h0100, 16'h0200); seal(16'hE0, 32, 0);
        scan(0, 256, 0); scn("R2", 1, 16'hE0, 0);

        // R1 bad length, short length, wrong version
        clear_mem(); put_pri(16'h00, 40, 16'h0100, 0); seal(16'h00, 48, 0);
        put_pri(16'h40, 16, 16'h0100, 0); seal(16'h40, 32, 0);
        put_pri(16'h80, 32, 16'h0200, 0); seal(16'h80, 32, 0);
        scan(0, 256, 0); scn("R1", 0, 0, 0);

        // R5 used zero and alloc below used rejected; first valid wins over a later one
        clear_mem(); put_alt(16'h10, 4, 0, 1); put_alt(16'h30, 2, 3, 1);
        put_alt(16'h51, 6, 6, 16'h4000); put_alt(16'h70, 9, 1, 16'h0002);
        scan(0, 256, 0); scn("R5", 1, 16'h51, 1);

        // R6 long layout wins over an earlier short header
        clear_mem(); put_alt(16'h08, 3, 2, 16'h0800);
        put_pri(16'hA0, 32, 16'h0100, 16'h0400); seal(16'hA0, 32, 0);
        scan(0, 256, 0); scn("R6", 1, 16'hA0, 0);

        // R9 two overlapping candidates, inner one valid
        clear_mem(); put_pri(16'h00, 64, 16'h0100, 0); put_pri(16'h10, 32, 16'h0100, 16'h0020);
        seal(16'h10, 32, 0); seal(16'h00, 64, 1);
        scan(0, 128, 0); scn("R9", 1, 16'h10, 0);

        // R9 third overlapping candidate finds no tracker and is dropped
        clear_mem(); put_pri(16'h00, 96, 16'h0100, 0); put_pri(16'h10, 64, 16'h0100, 0);
        put_pri(16'h20, 32, 16'h0100, 16'h0040);
        seal(16'h20, 32, 0); seal(16'h10, 64, 1); seal(16'h00, 96, 1);
        scan(0, 128, 0); scn("R9", 0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule